// File: doc/BRIEF.md
# Command Response Hunter

This block runs on the host side of a byte-oriented serial link, right after a command frame has gone out. It takes the opcode that was issued and a start strobe. It then pulls received bytes one at a time over a valid/ready stream and checks that the slave answered in two stages. First it hunts for the echo of the issued opcode. Once the echo is found, it hunts for a status byte of zero. Each hunt has its own bounded budget: the first read plus a parameterised number of retries.

The link-reset opcode is handled differently. Before the echo hunt starts, the block throws away exactly one received byte without looking at it. At the end of a check, the block raises a one-cycle done pulse together with either pass or fail, and goes back to idle. A bus error input aborts a check in progress at once, with a failure. Retrying the whole transaction and resetting the link are left to the logic around the block.

The receive stream follows valid/ready rules. A byte moves only on a cycle where `rx_valid` and `rx_ready` are both high. The block raises `rx_ready` only while a check is in progress, so it never accepts more than one byte per cycle. The source may hold `rx_valid` low for any number of cycles, and the block simply waits. A byte offered while `rx_ready` is low stays with the source.

Top module: `cmd_resp_hunter`

## Requirements
- R1: A `start` pulse while idle captures `opcode` and raises `rx_ready` on the next cycle. A later change of `opcode` does not affect the check in progress.
- R2: A byte is consumed only on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while idle, and bytes offered in idle produce no done pulse.
- R3: When the captured opcode equals RESET_OP (default 8'hCF), the first consumed byte is discarded whatever its value, even if it equals the opcode. It does not count against the echo budget.
- R4: In the echo hunt, a consumed byte equal to the captured opcode ends the hunt and starts the status hunt. Any other byte, including 8'h00, is a miss.
- R5: If RETRY+1 consecutive misses occur in the echo hunt (default RETRY=10, so 11 bytes), the check ends with fail.
- R6: In the status hunt, a consumed byte equal to 8'h00 ends the check with pass. Any other byte, including the opcode, is a miss.
- R7: If RETRY+1 consecutive misses occur in the status hunt, the check ends with fail.
- R8: `bus_err` high on any cycle of a check ends that check with fail on the next cycle. A byte offered on that same cycle is not evaluated.
- R9: `done` is high for exactly one cycle per check. On that cycle exactly one of `pass` and `fail` is high, and both are low at all other times. `rx_ready` is low on the done cycle.
- R10: A `start` pulse during a check is ignored. The check continues with the opcode captured at its own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a check when idle |
| opcode | input | DW | Opcode of the command just sent, sampled on start |
| bus_err | input | 1 | Transport error; aborts a running check |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | DW | Received byte |
| rx_ready | output | 1 | Block will take the offered byte (high only during a check) |
| done | output | 1 | One-cycle end-of-check pulse |
| pass | output | 1 | Both hunts succeeded (valid with done) |
| fail | output | 1 | A hunt ran out of budget or the bus failed (valid with done) |

## Verification
The hardest cases to reach are the budget edges. A hit must land on exactly the last permitted byte of a hunt, or the miss that exhausts the budget must fall in the status hunt after a successful echo. On top of that, the reset opcode shifts every count by the discarded byte. The stimulus sends exact byte sequences: ten misses followed by the target, eleven misses, and the reset opcode with a leading copy of itself. Each sequence is checked against the number of bytes the block should take before finishing. Valid gaps, a bus error in mid-hunt, and a second start during a check are layered on the same sequences. A behavioural model compares the outputs on every cycle.

// File: rtl/cmd_resp_pkg.sv
package cmd_resp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_ECHO = 2'd2,
    ST_STAT = 2'd3
  } hunt_st_e;
endpackage

// File: rtl/hunt_budget.sv
module hunt_budget #(
  parameter int RETRY = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);
  localparam int CW = $clog2(RETRY + 2);
  logic [CW-1:0] used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    used_q <= '0;
    else if (clr)  used_q <= '0;
    else if (bump) used_q <= used_q + 1'b1;
  end

  // Current byte is the final one the budget allows.
  assign last = (used_q == CW'(RETRY));
endmodule

// File: rtl/hunt_target.sv
module hunt_target
  import cmd_resp_pkg::*;
#(
  parameter int DW = 8
) (
  input  hunt_st_e        st,
  input  logic [DW-1:0]   op,
  input  logic [DW-1:0]   data,
  output logic            hit
);
  logic [DW-1:0] want;
  always_comb begin
    want = (st == ST_ECHO) ? op : '0;
    hit  = (data == want);
  end
endmodule

// File: rtl/cmd_resp_hunter.sv
module cmd_resp_hunter
  import cmd_resp_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          RETRY    = 10,
  parameter logic [7:0]  RESET_OP = 8'hCF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] opcode,
  input  logic          bus_err,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          done,
  output logic          pass,
  output logic          fail
);
  localparam logic [DW-1:0] RST_CODE = DW'(RESET_OP);

  hunt_st_e      st_q, st_d;
  logic [DW-1:0] op_q;
  logic          take, hit, last;
  logic          clr, bump;
  logic          fin, fin_ok;

  assign rx_ready = (st_q != ST_IDLE);
  assign take     = rx_valid & rx_ready;

  hunt_target #(.DW(DW)) u_tgt (
    .st   (st_q),
    .op   (op_q),
    .data (rx_data),
    .hit  (hit)
  );

  hunt_budget #(.RETRY(RETRY)) u_budget (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .bump  (bump),
    .last  (last)
  );

  always_comb begin
    st_d   = st_q;
    clr    = 1'b0;
    bump   = 1'b0;
    fin    = 1'b0;
    fin_ok = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          clr  = 1'b1;
          st_d = (opcode == RST_CODE) ? ST_SKIP : ST_ECHO;
        end
      end
      default: begin
        if (bus_err) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end else if (take) begin
          if (st_q == ST_SKIP) begin
            clr  = 1'b1;
            st_d = ST_ECHO;
          end else if (hit) begin
            clr = 1'b1;
            if (st_q == ST_ECHO) begin
              st_d = ST_STAT;
            end else begin
              fin    = 1'b1;
              fin_ok = 1'b1;
              st_d   = ST_IDLE;
            end
          end else if (last) begin
            fin  = 1'b1;
            st_d = ST_IDLE;
          end else begin
            bump = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= '0;
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) op_q <= opcode;
      done <= fin;
      pass <= fin & fin_ok;
      fail <= fin & ~fin_ok;
    end
  end
endmodule

// File: rtl/cmd_resp_hunter_chk.sv
module cmd_resp_hunter_chk #(
  parameter int DW    = 8,
  parameter int RETRY = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bus_err,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rx_ready,
  input logic          done,
  input logic          pass,
  input logic          fail
);
  localparam int MAXB = 2 * (RETRY + 1) + 1;
  localparam int KW   = $clog2(MAXB + 2) + 1;
  logic [KW-1:0] took;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     took <= '0;
    else if (!rx_ready)             took <= '0;
    else if (rx_valid && !bus_err)  took <= took + 1'b1;
  end

  // R9: one-cycle done with exactly one result
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  a_r9_result_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done);
  a_r9_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_ready);
  // R1: start from idle engages the stream
  a_r1_start_engages: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ready && start) |=> rx_ready);
  // R8: bus error aborts with fail
  a_r8_bus_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && bus_err) |=> (done && fail));
  // R6: pass follows acceptance of a zero byte
  a_r6_pass_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> ($past(rx_valid && rx_ready) && $past(rx_data) == '0));
  // R5 / R7: consumed bytes per check stay within both budgets plus skip
  a_r5_r7_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
    took <= KW'(MAXB));
endmodule

bind cmd_resp_hunter cmd_resp_hunter_chk #(.DW(DW), .RETRY(RETRY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .bus_err  (bus_err),
  .rx_valid (rx_valid),
  .rx_data  (rx_data),
  .rx_ready (rx_ready),
  .done     (done),
  .pass     (pass),
  .fail     (fail)
);

// File: tb/cmd_resp_hunter_tb_top.sv
module cmd_resp_hunter_tb_top;
  localparam int RETRY = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       bus_err = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_ready, done, pass, fail;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmd_resp_hunter #(.DW(8), .RETRY(RETRY), .RESET_OP(8'hCF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .done(done), .pass(pass), .fail(fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 skip, 2 echo, 3 status
  int       m_ph = 0;
  int       m_miss = 0;
  bit [7:0] m_op = 0;
  bit       m_done = 0, m_pass = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_miss = 0; m_done = 0; m_pass = 0;
    end else begin
      m_done = 0; m_pass = 0;
      if (m_ph == 0) begin
        if (start) begin
          m_op = opcode; m_miss = 0;
          m_ph = (opcode == 8'hCF) ? 1 : 2;
        end
      end else if (bus_err) begin
        m_done = 1; m_ph = 0;
      end else if (rx_valid) begin
        if (m_ph == 1) begin
          m_ph = 2; m_miss = 0;
        end else if (rx_data == ((m_ph == 2) ? m_op : 8'h00)) begin
          m_miss = 0;
          if (m_ph == 2) m_ph = 3;
          else begin m_done = 1; m_pass = 1; m_ph = 0; end
        end else if (m_miss == RETRY) begin
          m_done = 1; m_ph = 0;
        end else m_miss++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rx_ready == (m_ph != 0), "R2 rx_ready vs model", rx_ready, m_ph != 0);
      chk(done == m_done, "R9 done vs model", done, m_done);
      chk(pass == (m_done && m_pass), "R6 pass vs model", pass, m_done && m_pass);
      chk(fail == (m_done && !m_pass), "R7 fail vs model", fail, m_done && !m_pass);
    end
  end

  task automatic run_txn(input logic [7:0] op, input logic [7:0] q[$], input bit gaps,
                         input int err_at, input int restart_at, input bit exp_pass,
                         input int exp_used, input string tag);
    int  idx = 0;
    int  cyc = 0;
    bit  got = 0;
    bit  res = 0;
    int  e_at = err_at;
    int  r_at = restart_at;
    @(negedge clk);
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rx_ready == 1'b1, {tag, " R1 ready after start"}, rx_ready, 1);
    opcode = op ^ 8'h5A;
    while (!got && cyc < 300) begin
      if (done) begin
        got = 1; res = pass;
      end else begin
        rx_valid = 1'b0; rx_data = 8'h00; bus_err = 1'b0; start = 1'b0;
        if (e_at >= 0 && e_at == idx) begin bus_err = 1'b1; e_at = -1; end
        if (r_at >= 0 && r_at == idx) begin start = 1'b1; opcode = 8'h11; r_at = -1; end
        if (idx < q.size() && !(gaps && (cyc % 3 != 0))) begin
          rx_valid = 1'b1; rx_data = q[idx];
          if (rx_ready && !bus_err) idx++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    rx_valid = 1'b0; bus_err = 1'b0; start = 1'b0;
    chk(got, {tag, " done seen"}, got, 1);
    chk(res == exp_pass, {tag, " result"}, res, exp_pass);
    chk(idx == exp_used, {tag, " bytes consumed"}, idx, exp_used);
    chk(rx_ready == 1'b0, {tag, " R9 idle after done"}, rx_ready, 0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    chk(rx_ready == 0 && done == 0 && pass == 0 && fail == 0, "R9 reset state",
        {rx_ready, done, pass, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: bytes offered in idle are not taken
    rx_valid = 1'b1; rx_data = 8'hC9;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rx_ready == 0 && done == 0, "R2 idle ignores bytes", {rx_ready, done}, 0);
    end
    rx_valid = 1'b0;

    // R4 R6: normal response
    q = '{8'hFF, 8'hC9, 8'hFF, 8'h00};
    run_txn(8'hC9, q, 0, -1, -1, 1, 4, "R4 R6 basic");
    q = '{8'hC4, 8'h00};
    run_txn(8'hC4, q, 0, -1, -1, 1, 2, "R6 immediate");
    // R4: echo on last allowed byte, zero is a miss in echo hunt
    q = '{};
    for (int i = 0; i < RETRY; i++) q.push_back(i[0] ? 8'h00 : 8'h3C);
    q.push_back(8'hC7); q.push_back(8'h00);
    run_txn(8'hC7, q, 0, -1, -1, 1, RETRY + 2, "R4 echo at limit");
    // R5: echo budget exhausted
    q = '{};
    for (int i = 0; i < RETRY + 1; i++) q.push_back(8'h00);
    q.push_back(8'hC7);
    run_txn(8'hC7, q, 0, -1, -1, 0, RETRY + 1, "R5 echo exhausted");
    // R6: status zero on last allowed byte, opcode is a miss in status hunt
    q = '{8'hCA};
    for (int i = 0; i < RETRY; i++) q.push_back(8'hCA);
    q.push_back(8'h00);
    run_txn(8'hCA, q, 0, -1, -1, 1, RETRY + 2, "R6 status at limit");
    // R7: status budget exhausted
    q = '{8'hCA};
    for (int i = 0; i < RETRY + 1; i++) q.push_back(8'h81);
    q.push_back(8'h00);
    run_txn(8'hCA, q, 0, -1, -1, 0, RETRY + 2, "R7 status exhausted");
    // R3: reset opcode discards first byte even if it matches
    q = '{8'hCF, 8'hCF, 8'h00};
    run_txn(8'hCF, q, 0, -1, -1, 1, 3, "R3 skip matching byte");
    q = '{8'hCF};
    for (int i = 0; i < RETRY; i++) q.push_back(8'h12);
    q.push_back(8'hCF); q.push_back(8'h00);
    run_txn(8'hCF, q, 0, -1, -1, 1, RETRY + 3, "R3 skip not counted");
    q = '{8'hCF};
    for (int i = 0; i < RETRY + 1; i++) q.push_back(8'h12);
    run_txn(8'hCF, q, 0, -1, -1, 0, RETRY + 2, "R3 R5 reset exhausted");
    // R8: bus error aborts mid status hunt
    q = '{8'hC9, 8'h44, 8'h00};
    run_txn(8'hC9, q, 0, 2, -1, 0, 2, "R8 bus abort");
    // R2: gaps in valid
    q = '{8'h01, 8'hC8, 8'h02, 8'h00};
    run_txn(8'hC8, q, 1, -1, -1, 1, 4, "R2 valid gaps");
    // R10: start during check ignored
    q = '{8'h11, 8'hC3, 8'h00};
    run_txn(8'hC3, q, 0, -1, 1, 1, 3, "R10 restart ignored");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule